// File: doc/BRIEF.md
# Sound Chip Write Wait-State Controller

This block sits between an ISA expansion bus and a pair of sound generator chips. When the host writes to either chip, the chip may need extra chip-clock cycles before it accepts the data. This happens mainly for amplitude loads, which are delayed by an amount that depends on the time since the previous amplitude load. The controller detects the write and pulls the shared bus ready line low. It keeps the line low until a sound chip returns its active-low acknowledge, so the host cycle is stretched by exactly the time the chip needs.

The ready line is shared by every slot. The block therefore only pulls it low or leaves it floating. A bus reset releases it at once. A timeout releases it after a bounded number of chip clocks, so a missing acknowledge cannot hang the bus, and a sticky flag records that the timeout fired. An enable input turns the stretching off entirely. The block runs on the chip clock of about 7.16 MHz. The strobe, select and acknowledge inputs are resynchronised to that clock.

Top module: `snd_iordy_ctrl`

## Requirements
- R1: While `rst_n` is low, `rdy_pull_en` and `tmo_flag` are 0, and `io_ready` is not driven low.
- R2: Three clock edges after `wr_n` goes low while at least one bit of `sel_n` is low, `rdy_pull_en` becomes 1, provided `wait_en` is 1 and `bus_rst` is 0. This edge is the first edge after the change in the input, plus two synchroniser stages, plus the state register.
- R3: During a wait, a low on either bit of `ack_n` clears `rdy_pull_en` at the second clock edge after the edge that samples it. The bit of `ack_n` does not have to match the chip that was written.
- R4: A read (`wr_n` high) never starts a wait. A write with both bits of `sel_n` high never starts a wait.
- R5: While `bus_rst` is 1, `rdy_pull_en` is 0 in the same cycle, and the wait is cleared at the next edge.
- R6: While `wait_en` is 0, `rdy_pull_en` is 0 and no new wait is entered.
- R7: With no acknowledge, `rdy_pull_en` stays 1 for exactly 64 clock cycles and then clears. `tmo_flag` then becomes 1 and stays 1 until `rst_n` goes low.
- R8: If an acknowledge reaches the controller in the same cycle as the write edge, no wait is entered.
- R9: Holding `wr_n` low after a wait has ended does not start a second wait. A new wait needs `wr_n` to go high and then low again.
- R10: `io_ready` is 0 whenever `rdy_pull_en` is 1. Otherwise it is high impedance. It is never driven to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, about 7.16 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rst | input | 1 | Bus reset, active high, synchronous to `clk` |
| wait_en | input | 1 | 1 enables write stretching |
| wr_n | input | 1 | Bus write strobe, active low |
| sel_n | input | 2 | Per-chip select, active low |
| ack_n | input | 2 | Per-chip data acknowledge, active low |
| rdy_pull_en | output | 1 | 1 when the ready line is pulled low |
| io_ready | output | 1 | Open-drain ready line: 0 or high impedance |
| tmo_flag | output | 1 | Sticky flag: a wait ended by timeout |

## Verification
The properties assume the following about the inputs:
- `bus_rst` and `wait_en` are stable around each clock edge.
- An acknowledge is a low pulse that arrives only while a write is pending.
- Successive writes are separated by enough idle cycles to let the two synchroniser stages settle.

The stimulus meets these assumptions by changing every input just after the falling clock edge and by returning to idle between scenarios. The one exception is the same-cycle scenario, where the write and the acknowledge change together on purpose.

// File: rtl/snd_iordy_pkg.sv
package snd_iordy_pkg;
  localparam int unsigned NCHIP = 2;
  typedef enum logic {ST_IDLE = 1'b0, ST_HOLD = 1'b1} wait_st_e;
endpackage

// File: rtl/snd_sync2.sv
module snd_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= RST_VAL;
        st2 <= RST_VAL;
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/snd_tmo_cnt.sv
module snd_tmo_cnt #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = run && (cnt_q == LAST);

  // R7: a running count never passes the limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == LAST) |=> !run || cnt_q == '0)
    else $error("p_cnt_bound_r7");
endmodule

// File: rtl/snd_wait_fsm.sv
module snd_wait_fsm
  import snd_iordy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack_any,
  input  logic tmo_hit,
  input  logic wait_en,
  input  logic bus_rst,
  output logic waiting,
  output logic tmo_flag
);
  wait_st_e st_q, st_d;
  logic     flag_q, flag_d;

  always_comb begin
    st_d   = st_q;
    flag_d = flag_q;
    if (bus_rst || !wait_en) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start && !ack_any) st_d = ST_HOLD;
        ST_HOLD: begin
          if (ack_any) st_d = ST_IDLE;
          else if (tmo_hit) begin
            st_d   = ST_IDLE;
            flag_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
    end
  end

  assign waiting  = (st_q == ST_HOLD);
  assign tmo_flag = flag_q;

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ack_any && wait_en && !bus_rst && !waiting) |=> waiting)
    else $error("p_enter_r2");
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && ack_any) |=> !waiting)
    else $error("p_ack_release_r3");
  p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && ack_any) |=> !waiting)
    else $error("p_same_cycle_r8");
  p_tmo_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && tmo_hit) |=> !waiting)
    else $error("p_tmo_release_r7");
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |=> tmo_flag)
    else $error("p_flag_sticky_r7");
endmodule

// File: rtl/snd_iordy_ctrl.sv
module snd_iordy_ctrl
  import snd_iordy_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             wait_en,
  input  logic             wr_n,
  input  logic [NCHIP-1:0] sel_n,
  input  logic [NCHIP-1:0] ack_n,
  output logic             rdy_pull_en,
  output wire              io_ready,
  output logic             tmo_flag
);
  localparam int unsigned SW = 1 + 2 * NCHIP;

  logic [SW-1:0]    raw_in, syn_in;
  logic             wr_s;
  logic [NCHIP-1:0] sel_s, ack_s;
  logic             wq, wq_q, start, ack_any, waiting, tmo_hit;

  assign raw_in = {wr_n, sel_n, ack_n};

  snd_sync2 #(.W(SW), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign wr_s  = syn_in[SW-1];
  assign sel_s = syn_in[2*NCHIP-1:NCHIP];
  assign ack_s = syn_in[NCHIP-1:0];

  assign wq      = !wr_s && (sel_s != {NCHIP{1'b1}});
  assign ack_any = (ack_s != {NCHIP{1'b1}});
  assign start   = wq && !wq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wq_q <= 1'b0;
    else        wq_q <= wq;
  end

  snd_tmo_cnt #(.LIMIT(TMO_CYCLES)) i_tmo (
    .clk(clk), .rst_n(rst_n), .run(waiting), .hit(tmo_hit)
  );

  snd_wait_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ack_any(ack_any),
    .tmo_hit(tmo_hit), .wait_en(wait_en), .bus_rst(bus_rst),
    .waiting(waiting), .tmo_flag(tmo_flag)
  );

  assign rdy_pull_en = waiting && wait_en && !bus_rst;
  assign io_ready    = rdy_pull_en ? 1'b0 : 1'bz;

  p_bus_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> !rdy_pull_en)
    else $error("p_bus_rst_r5");
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_en |-> !rdy_pull_en)
    else $error("p_disabled_r6");
  p_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && !wq) |=> !waiting)
    else $error("p_no_read_r4");
  p_pull_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pull_en |-> (io_ready == 1'b0))
    else $error("p_pull_low_r10");
endmodule

// File: tb/test_snd_iordy_ctrl.sv
`timescale 1ns/100ps
module test_snd_iordy_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       wait_en = 1'b1;
  logic       wr_n = 1'b1;
  logic [1:0] sel_n = 2'b11;
  logic [1:0] ack_n = 2'b11;
  logic       rdy_pull_en, tmo_flag;
  wire        io_ready;

  int    n_chk = 0, n_fail = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;

  snd_iordy_ctrl i_snd_iordy_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wait_en(wait_en),
    .wr_n(wr_n), .sel_n(sel_n), .ack_n(ack_n),
    .rdy_pull_en(rdy_pull_en), .io_ready(io_ready), .tmo_flag(tmo_flag)
  );

  // behavioural reference: inputs seen after two stages, then a wait bit
  bit         m_wr1 = 1, m_wr2 = 1;
  bit   [1:0] m_sel1 = 3, m_sel2 = 3, m_ack1 = 3, m_ack2 = 3;
  bit         m_wait = 0, m_prev = 0, m_flag = 0;
  int         m_len = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wr1 = 1; m_wr2 = 1; m_sel1 = 3; m_sel2 = 3; m_ack1 = 3; m_ack2 = 3;
      m_wait = 0; m_prev = 0; m_flag = 0; m_len = 0;
    end else begin
      bit wr_req, acked, nw;
      wr_req = !m_wr2 && (m_sel2 != 2'b11);
      acked  = (m_ack2 != 2'b11);
      nw = m_wait;
      if (bus_rst || !wait_en) nw = 0;
      else if (m_wait) begin
        if (acked) nw = 0;
        else if (m_len == 63) begin nw = 0; m_flag = 1; end
      end else if (wr_req && !m_prev && !acked) nw = 1;
      m_len  = nw && m_wait ? m_len + 1 : 0;
      m_wait = nw;
      m_prev = wr_req;
      m_wr2 = m_wr1; m_wr1 = wr_n;
      m_sel2 = m_sel1; m_sel1 = sel_n;
      m_ack2 = m_ack1; m_ack1 = ack_n;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_pull;
    e_pull = m_wait && wait_en && !bus_rst && rst_n;
    check(cur, rdy_pull_en, e_pull, "rdy_pull_en");
    check(cur, tmo_flag, m_flag, "tmo_flag");
    if (rdy_pull_en) check("R10", io_ready, 1'b0, "io_ready");
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic do_write(input logic [1:0] sel, input int hold);
    sel_n = sel; wr_n = 1'b0;
    idle(hold);
    wr_n = 1'b1; sel_n = 2'b11;
  endtask

  task automatic pulse_ack(input logic [1:0] a);
    ack_n = a; idle(1); ack_n = 2'b11;
  endtask

  initial begin
    #1;
    cur = "R1";
    idle(4);
    check("R1", rdy_pull_en, 1'b0, "reset pull");
    check("R1", tmo_flag, 1'b0, "reset flag");
    rst_n = 1'b1;
    idle(3);

    cur = "R2"; sel_n = 2'b10; wr_n = 1'b0;
    idle(2); check("R2", rdy_pull_en, 1'b0, "before third edge");
    idle(1); check("R2", rdy_pull_en, 1'b1, "after third edge");
    idle(3); pulse_ack(2'b10); wr_n = 1'b1; sel_n = 2'b11; idle(8);
    check("R2", rdy_pull_en, 1'b0, "released");

    cur = "R3"; do_write(2'b01, 2); idle(5);
    pulse_ack(2'b10); idle(1);
    check("R3", rdy_pull_en, 1'b1, "still held one edge");
    idle(1); check("R3", rdy_pull_en, 1'b0, "other chip ack");
    idle(5);

    cur = "R4"; sel_n = 2'b00; idle(6); sel_n = 2'b11;
    wr_n = 1'b0; idle(6); wr_n = 1'b1; idle(6);
    check("R4", rdy_pull_en, 1'b0, "no wait");

    cur = "R5"; do_write(2'b10, 2); idle(4);
    bus_rst = 1'b1; #0.5;
    check("R5", rdy_pull_en, 1'b0, "immediate release");
    idle(3); bus_rst = 1'b0; idle(4);
    check("R5", rdy_pull_en, 1'b0, "stays released");

    cur = "R6"; wait_en = 1'b0; do_write(2'b10, 2); idle(8);
    check("R6", rdy_pull_en, 1'b0, "disabled");
    wait_en = 1'b1; idle(4);

    cur = "R8"; sel_n = 2'b01; wr_n = 1'b0; ack_n = 2'b01;
    idle(1); ack_n = 2'b11; idle(4);
    check("R8", rdy_pull_en, 1'b0, "same-cycle ack");
    wr_n = 1'b1; sel_n = 2'b11; idle(5);

    cur = "R9"; sel_n = 2'b10; wr_n = 1'b0; idle(8);
    pulse_ack(2'b10); idle(60);
    check("R9", rdy_pull_en, 1'b0, "no second wait");
    wr_n = 1'b1; sel_n = 2'b11; idle(5);

    cur = "R7"; do_write(2'b10, 2); idle(1);
    check("R7", rdy_pull_en, 1'b1, "timeout wait held");
    idle(80);
    check("R7", rdy_pull_en, 1'b0, "timeout release");
    check("R7", tmo_flag, 1'b1, "flag set");
    do_write(2'b01, 2); idle(4); pulse_ack(2'b01); idle(10);
    check("R7", tmo_flag, 1'b1, "flag sticky");

    cur = "R1"; rst_n = 1'b0; idle(2);
    check("R1", tmo_flag, 1'b0, "flag cleared by reset");
    rst_n = 1'b1; idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule